// File: doc/BRIEF.md
# Sequential Limb Multiplier, 64 x 64 to 128 Bits

This block returns the exact 128-bit unsigned product of two 64-bit operands. It has only one half-width (32 x 32 to 64) multiplier. Each operand is cut into an upper and a lower 32-bit limb. The block forms the four limb cross products one per clock cycle and folds each into a running sum as soon as it appears.

The running sum lives in two 64-bit columns. The low column takes the low-by-low product plus the low halves of the two mixed products, each shifted up 32 bits. Each of those two additions can wrap. Every wrap is counted as a carry, so the count reaches at most two. The high column then takes that count, the upper halves of the mixed products and the high-by-high product. Every adder in the datapath is 64 bits wide.

A caller drives `start` with both operands while the block is idle. `busy` stays high for four cycles. `done` then pulses for one cycle with the result on `product`. The result stays there until the next accepted start has run to completion.

Top module: `limb_mul64`

## Requirements
- R1: `start` high while `busy` is low captures `a_in` and `b_in`, and `busy` is high in the following cycle.
- R2: `done` rises exactly four cycles after the capturing edge. It is high for a single cycle, and `busy` is low in that same cycle.
- R3: When `done` is high, `product` equals the full 128-bit unsigned product of the captured operands.
- R4: Bits 31:0 of `product` equal the low 32 bits of (low limb of A) x (low limb of B). The low limb of an operand is its bits 31:0, and the high limb is its bits 63:32.
- R5: A `start` that arrives while `busy` is high has no effect. The running computation finishes on time with the operands captured first.
- R6: `product` changes only in a cycle in which `done` is high, and otherwise holds its last value.
- R7: The number of carries out of the low column is 0, 1 or 2. Operands that make both low-column additions wrap still give the exact product.
- R8: The high-column sum never needs a 65th bit.
- R9: After reset, `busy`, `done` and `product` are all zero.
- R10: Zero operands give zero. The all-ones operand squared gives 0xFFFFFFFFFFFFFFFE0000000000000001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a multiply, taken only while idle |
| a_in | input | 64 | Multiplicand |
| b_in | input | 64 | Multiplier |
| busy | output | 1 | High while the four limb products are being accumulated |
| done | output | 1 | One-cycle pulse marking a fresh result |
| product | output | 128 | Full unsigned product, held between results |

## Verification
The assertions assume that `start` is free to toggle at any time, including while `busy` is high. The bench exercises exactly that by raising `start` with different operands partway through a computation. The carry and overflow assertions assume that the operands are stable inside the block once captured, so the bench changes `a_in` and `b_in` freely after capture to show that they are not re-read. The random operand pairs come from a fixed seed. A directed search picks a pair that makes both low-column additions wrap.

// File: rtl/limb_mul64.sv
`timescale 1ns/1ps
module limb_mul64 #(
  parameter int HALF_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [2*HALF_W-1:0]   a_in,
  input  logic [2*HALF_W-1:0]   b_in,
  output logic                  busy,
  output logic                  done,
  output logic [4*HALF_W-1:0]   product
);
  localparam int W  = 2 * HALF_W;
  localparam int PW = 4 * HALF_W;

  logic [W-1:0]  a_q, b_q;
  logic [1:0]    step;
  logic          busy_q, done_q;
  logic [W-1:0]  lo_acc, hi_acc;
  logic [1:0]    cnt;
  logic [PW-1:0] prod_q;

  // step order P0=AL*BL, P1=AH*BL, P2=AL*BH, P3=AH*BH
  wire [HALF_W-1:0] op_x = step[0] ? a_q[W-1:HALF_W] : a_q[HALF_W-1:0];
  wire [HALF_W-1:0] op_y = step[1] ? b_q[W-1:HALF_W] : b_q[HALF_W-1:0];
  wire [W-1:0] mul_out = W'(op_x) * W'(op_y);

  wire [W-1:0] shifted = {mul_out[HALF_W-1:0], {HALF_W{1'b0}}};
  wire [W-1:0] lo_sum  = lo_acc + shifted;
  wire         wrap    = lo_sum < lo_acc;
  wire [W-1:0] hi_mid  = hi_acc + W'(mul_out[W-1:HALF_W]);
  wire [W-1:0] hi_fin  = hi_acc + mul_out + W'(cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= '0;
      b_q    <= '0;
      step   <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      lo_acc <= '0;
      hi_acc <= '0;
      cnt    <= '0;
      prod_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          a_q    <= a_in;
          b_q    <= b_in;
          step   <= '0;
          busy_q <= 1'b1;
        end
      end else begin
        step <= step + 2'd1;
        case (step)
          2'd0: begin
            lo_acc <= mul_out;
            hi_acc <= '0;
            cnt    <= '0;
          end
          2'd1, 2'd2: begin
            lo_acc <= lo_sum;
            hi_acc <= hi_mid;
            cnt    <= cnt + {1'b0, wrap};
          end
          default: begin
            prod_q <= {hi_fin, lo_acc};
            done_q <= 1'b1;
            busy_q <= 1'b0;
          end
        endcase
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign product = prod_q;
endmodule

// File: rtl/limb_mul64_chk.sv
`timescale 1ns/1ps
module limb_mul64_chk #(
  parameter int HALF_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic                busy,
  input logic                done,
  input logic [4*HALF_W-1:0] product,
  input logic [1:0]          step,
  input logic [2*HALF_W-1:0] mul_out,
  input logic [2*HALF_W-1:0] lo_acc,
  input logic [2*HALF_W-1:0] hi_acc,
  input logic [1:0]          cnt
);
  localparam int W = 2 * HALF_W;

  logic [W:0]   wide_lo;
  logic [W+1:0] wide_hi;
  assign wide_lo = {1'b0, lo_acc} + {1'b0, mul_out[HALF_W-1:0], {HALF_W{1'b0}}};
  assign wide_hi = {2'b00, hi_acc} + {2'b00, mul_out} + (W+2)'(cnt);

  assert_capture_R1: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);
  assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_done_after_last_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && step == 2'd3) |=> done);
  assert_busy_ignores_start_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && step != 2'd3) |=> (busy && step == $past(step) + 2'd1));
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(product));
  assert_carry_range_R7: assert property (@(posedge clk) disable iff (rst)
    cnt <= 2'd2);
  assert_carry_agrees_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && (step == 2'd1 || step == 2'd2)) |=>
      (cnt == $past(cnt) + {1'b0, $past(wide_lo[W])}));
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && step == 2'd3) |-> (wide_hi[W+1:W] == 2'b00));
endmodule

bind limb_mul64 limb_mul64_chk #(.HALF_W(HALF_W)) chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .product(product), .step(step), .mul_out(mul_out),
  .lo_acc(lo_acc), .hi_acc(hi_acc), .cnt(cnt)
);

// File: tb/limb_mul64_test.sv
`timescale 1ns/1ps
module limb_mul64_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [63:0]  a_in = '0, b_in = '0;
  logic         busy, done;
  logic [127:0] product;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  limb_mul64 uut (
    .clk(clk), .rst(rst), .start(start), .a_in(a_in), .b_in(b_in),
    .busy(busy), .done(done), .product(product)
  );

  function automatic logic [127:0] ref_mul(input logic [63:0] a, input logic [63:0] b);
    return {64'd0, a} * {64'd0, b};
  endfunction

  function automatic int low_carries(input logic [63:0] a, input logic [63:0] b);
    logic [64:0] s0, s1;
    logic [63:0] p0, p1, p2;
    p0 = {32'd0, a[31:0]}  * {32'd0, b[31:0]};
    p1 = {32'd0, a[63:32]} * {32'd0, b[31:0]};
    p2 = {32'd0, a[31:0]}  * {32'd0, b[63:32]};
    s0 = {1'b0, p0} + {1'b0, p1[31:0], 32'd0};
    s1 = {1'b0, s0[63:0]} + {1'b0, p2[31:0], 32'd0};
    return int'(s0[64]) + int'(s1[64]);
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one multiply; optional interfering start while busy
  task automatic run(input logic [63:0] a, input logic [63:0] b,
                     input bit poke, input string tag);
    logic [127:0] exp;
    int waited;
    exp = ref_mul(a, b);
    @(negedge clk);
    a_in = a; b_in = b; start = 1'b1;
    @(negedge clk);
    check(busy == 1'b1, "R1 busy after start", {127'd0, busy}, 128'd1);
    start = 1'b0;
    a_in = ~a; b_in = b ^ 64'h5A5A;
    waited = 1;
    while (!done && waited < 12) begin
      if (poke && waited == 2) begin
        start = 1'b1; a_in = 64'h1234; b_in = 64'h5678;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      waited++;
    end
    start = 1'b0;
    check(waited == 5, "R2 done latency", 128'(waited), 128'd5);
    check(busy == 1'b0, "R2 busy low at done", {127'd0, busy}, 128'd0);
    check(product == exp, {"R3 product ", tag}, product, exp);
    check(product[31:0] == 32'(({32'd0, a[31:0]} * {32'd0, b[31:0]})),
          "R4 low limb", {96'd0, product[31:0]}, {96'd0, exp[31:0]});
    if (poke) check(product == exp, "R5 start while busy ignored", product, exp);
    @(negedge clk);
    check(done == 1'b0, "R2 done single cycle", {127'd0, done}, 128'd0);
    check(product == exp, "R6 product held", product, exp);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] ca, cb;
    bit found;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(busy == 1'b0, "R9 reset busy", {127'd0, busy}, 128'd0);
    check(done == 1'b0, "R9 reset done", {127'd0, done}, 128'd0);
    check(product == 128'd0, "R9 reset product", product, 128'd0);

    run(64'd0, 64'd0, 1'b0, "R10 zero");
    check(product == 128'd0, "R10 zero operands", product, 128'd0);
    run(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R10 ones");
    check(product == 128'hFFFFFFFFFFFFFFFE0000000000000001, "R10 all ones squared",
          product, 128'hFFFFFFFFFFFFFFFE0000000000000001);
    run(64'd1, 64'hDEAD_BEEF_0123_4567, 1'b0, "unit");
    run(64'h0000_0001_0000_0000, 64'h0000_0001_0000_0000, 1'b0, "limb boundary");
    run(64'hCAFE_F00D_8765_4321, 64'h0BAD_C0DE_1357_9BDF, 1'b1, "R5 poke");

    found = 1'b0;
    for (int i = 0; i < 20000 && !found; i++) begin
      ca = {$urandom, $urandom};
      cb = {$urandom, $urandom};
      if (low_carries(ca, cb) == 2) found = 1'b1;
    end
    check(found, "R7 double carry operands found", 128'(found), 128'd1);
    if (found) run(ca, cb, 1'b0, "R7 both carries");

    // R6: idle with changing inputs, start low, product must not move
    begin
      logic [127:0] held;
      held = product;
      for (int k = 0; k < 6; k++) begin
        a_in = {$urandom, $urandom}; b_in = {$urandom, $urandom};
        @(negedge clk);
      end
      check(product == held, "R6 idle hold", product, held);
    end

    for (int n = 0; n < 200; n++) begin
      run({$urandom, $urandom}, {$urandom, $urandom}, (n % 7) == 0, "R3 random");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule